// File: doc/BRIEF.md
# Two-Stage Watchdog Timer with Early Warning and Reset Request

This block is a watchdog timer for a chip's peripheral space. It advances one counter on a slow tick enable, nominally 32768 ticks per second, so a timeout of N seconds is programmed as N x 32768 counts. The count is compared against two thresholds that software programs. The first threshold, called the warning threshold, produces a single-cycle interrupt pulse so that software can save diagnostic state. The second, called the kill threshold, raises a reset request for the system reset controller. Software keeps the system alive by writing the restart register periodically, which clears the count.

The two thresholds are independent, and software sets their order. If the kill threshold is reached first, the reset request wins and the warning never fires. A small register bus gives access to five words: restart, enable, status, warning threshold and kill threshold. Status returns the count shifted left by three, with three flag bits below it.

Control is a five-state machine. The states are `ST_IDLE` (stopped, warning armed), `ST_ARMED` (counting, warning armed), `ST_BARKED` (counting, warning already fired), `ST_HALTED` (stopped, warning already fired) and `ST_BITTEN` (reset requested, terminal). The named transitions work as follows:
- *enable/disable* moves between IDLE and ARMED, or between HALTED and BARKED.
- *warn* goes from IDLE or ARMED to BARKED.
- *rearm* is a restart that goes from BARKED or HALTED back to ARMED or IDLE.
- *kill* goes from any non-terminal state to BITTEN.
- *block reset* returns BITTEN to IDLE.

Top module: `bark_bite_wdog`

## Requirements
- R1: After `rst_n` the count, the enable, both thresholds and both outputs are zero, and the status word reads 0.
- R2: While enabled and not in BITTEN, the count rises by exactly one on each cycle with `tick_en` high. It never wraps: it holds at its all-ones maximum. Status at offset 0x44 reads {count, bit2 = reset requested, bit1 = warning spent, bit0 = enable}.
- R3: A write to offset 0x38 with bit 0 set clears the count on the next clock edge and re-arms the warning. A write with bit 0 clear has no effect.
- R4: A write to offset 0x40 enables the block when the value is nonzero and disables it when the value is zero. While disabled, the count holds, and neither `bark_irq` nor `bite_req` rises.
- R5: `bark_irq` is high for exactly one cycle, one edge after the count register is at or above the warning threshold (offset 0x4C) while enabled. It fires at most once between restarts.
- R6: `bite_req` rises one edge after the count register is at or above the kill threshold (offset 0x5C) while enabled. It stays high through restarts and disables until `rst_n`, and the count freezes once it is set.
- R7: If the kill condition holds on or before the edge where the warning would fire, the warning never fires.
- R8: The threshold registers are CNT_W bits wide and read back as written, with the upper bits zero. A write to an unmapped offset changes nothing, and an unmapped offset reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Count enable, one cycle per watchdog tick |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | ADDR_W | Byte offset of the accessed word |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for `bus_addr`, combinational |
| bark_irq | output | 1 | Single-cycle warning interrupt pulse |
| bite_req | output | 1 | Sticky reset request |

## Verification
Register writes take effect at the edge that ends the write cycle. The count reacts to `tick_en` at that same edge. Both outputs are registered, so each follows one edge after the count register meets its threshold. `bus_rdata` is combinational and is valid in the cycle in which the address is presented. The bench drives inputs on the falling edge and samples a quarter period later. A bench model replays the same rules edge by edge and is compared on every cycle. Directed cases confirm the exact frozen count after a kill, and the number of pulses over each window.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_ARMED  = 3'd1,
        ST_BARKED = 3'd2,
        ST_HALTED = 3'd3,
        ST_BITTEN = 3'd4
    } wdog_state_e;

endpackage

// File: rtl/wdog_regs.sv
module wdog_regs #(
    parameter int unsigned CNT_W       = 20,
    parameter int unsigned ADDR_W      = 8,
    parameter int unsigned DATA_W      = 32,
    parameter int unsigned OFF_RESTART = 'h38,
    parameter int unsigned OFF_ENABLE  = 'h40,
    parameter int unsigned OFF_STATUS  = 'h44,
    parameter int unsigned OFF_WARN    = 'h4C,
    parameter int unsigned OFF_KILL    = 'h5C
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic [CNT_W-1:0]  count,
    input  logic              spent,
    input  logic              bitten,
    output logic              en,
    output logic [CNT_W-1:0]  warn_thr,
    output logic [CNT_W-1:0]  kill_thr,
    output logic              restart,
    output logic [DATA_W-1:0] bus_rdata
);

    localparam logic [ADDR_W-1:0] A_RESTART = ADDR_W'(OFF_RESTART);
    localparam logic [ADDR_W-1:0] A_ENABLE  = ADDR_W'(OFF_ENABLE);
    localparam logic [ADDR_W-1:0] A_STATUS  = ADDR_W'(OFF_STATUS);
    localparam logic [ADDR_W-1:0] A_WARN    = ADDR_W'(OFF_WARN);
    localparam logic [ADDR_W-1:0] A_KILL    = ADDR_W'(OFF_KILL);

    logic hit_restart, hit_enable, hit_status, hit_warn, hit_kill;

    always_comb begin
        hit_restart = (bus_addr == A_RESTART);
        hit_enable  = (bus_addr == A_ENABLE);
        hit_status  = (bus_addr == A_STATUS);
        hit_warn    = (bus_addr == A_WARN);
        hit_kill    = (bus_addr == A_KILL);
    end

    assign restart = bus_wr && hit_restart && bus_wdata[0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en       <= 1'b0;
            warn_thr <= '0;
            kill_thr <= '0;
        end else if (bus_wr) begin
            if (hit_enable) en       <= (bus_wdata != '0);
            if (hit_warn)   warn_thr <= bus_wdata[CNT_W-1:0];
            if (hit_kill)   kill_thr <= bus_wdata[CNT_W-1:0];
        end
    end

    always_comb begin
        if (hit_enable)      bus_rdata = DATA_W'(en);
        else if (hit_status) bus_rdata = DATA_W'({count, bitten, spent, en});
        else if (hit_warn)   bus_rdata = DATA_W'(warn_thr);
        else if (hit_kill)   bus_rdata = DATA_W'(kill_thr);
        else                 bus_rdata = '0;
    end

endmodule

// File: rtl/wdog_count.sv
module wdog_count #(
    parameter int unsigned CNT_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             run,
    input  logic             tick_en,
    output logic [CNT_W-1:0] count
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            count <= '0;
        else if (restart)
            count <= '0;
        else if (run && tick_en && (count != CNT_MAX))
            count <= count + 1'b1;
    end

endmodule

// File: rtl/wdog_fsm.sv
module wdog_fsm
    import wdog_pkg::*;
#(
    parameter int unsigned CNT_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             restart,
    input  logic [CNT_W-1:0] count,
    input  logic [CNT_W-1:0] warn_thr,
    input  logic [CNT_W-1:0] kill_thr,
    output logic             spent,
    output logic             bitten,
    output logic             bark_irq,
    output logic             bite_req
);

    wdog_state_e state, nxt;
    logic        kill_hit, warn_hit, fire_warn;

    always_comb begin
        kill_hit = en && (count >= kill_thr);
        warn_hit = en && (count >= warn_thr);
    end

    always_comb begin
        nxt       = state;
        fire_warn = 1'b0;
        unique case (state)
            ST_IDLE, ST_ARMED: begin
                if (kill_hit)
                    nxt = ST_BITTEN;
                else if (!restart && warn_hit) begin
                    nxt       = ST_BARKED;
                    fire_warn = 1'b1;
                end else
                    nxt = en ? ST_ARMED : ST_IDLE;
            end
            ST_BARKED, ST_HALTED: begin
                if (kill_hit)
                    nxt = ST_BITTEN;
                else if (restart)
                    nxt = en ? ST_ARMED : ST_IDLE;
                else
                    nxt = en ? ST_BARKED : ST_HALTED;
            end
            ST_BITTEN: nxt = ST_BITTEN;
            default:   nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bark_irq <= 1'b0;
            bite_req <= 1'b0;
        end else begin
            bark_irq <= fire_warn;
            bite_req <= bite_req || (nxt == ST_BITTEN);
        end
    end

    always_comb begin
        spent  = (state == ST_BARKED) || (state == ST_HALTED);
        bitten = (state == ST_BITTEN);
    end

endmodule

// File: rtl/bark_bite_wdog.sv
module bark_bite_wdog #(
    parameter int unsigned CNT_W       = 20,
    parameter int unsigned ADDR_W      = 8,
    parameter int unsigned DATA_W      = 32,
    parameter int unsigned OFF_RESTART = 'h38,
    parameter int unsigned OFF_ENABLE  = 'h40,
    parameter int unsigned OFF_STATUS  = 'h44,
    parameter int unsigned OFF_WARN    = 'h4C,
    parameter int unsigned OFF_KILL    = 'h5C
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              bark_irq,
    output logic              bite_req
);

    logic             en, restart, spent, bitten;
    logic [CNT_W-1:0] count, warn_thr, kill_thr;

    wdog_regs #(
        .CNT_W(CNT_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
        .OFF_RESTART(OFF_RESTART), .OFF_ENABLE(OFF_ENABLE),
        .OFF_STATUS(OFF_STATUS), .OFF_WARN(OFF_WARN), .OFF_KILL(OFF_KILL)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .count(count), .spent(spent), .bitten(bitten),
        .en(en), .warn_thr(warn_thr), .kill_thr(kill_thr),
        .restart(restart), .bus_rdata(bus_rdata)
    );

    wdog_count #(.CNT_W(CNT_W)) u_count (
        .clk(clk), .rst_n(rst_n), .restart(restart),
        .run(en && !bitten), .tick_en(tick_en), .count(count)
    );

    wdog_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .en(en), .restart(restart), .count(count),
        .warn_thr(warn_thr), .kill_thr(kill_thr), .spent(spent),
        .bitten(bitten), .bark_irq(bark_irq), .bite_req(bite_req)
    );

endmodule

// File: rtl/wdog_chk.sv
module wdog_chk #(
    parameter int unsigned CNT_W = 20
) (
    input logic             clk,
    input logic             rst_n,
    input logic             en,
    input logic             restart,
    input logic [CNT_W-1:0] count,
    input logic             bark_irq,
    input logic             bite_req
);

    // R5
    bark_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bark_irq |=> !bark_irq);

    // R6
    bite_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bite_req |=> bite_req);

    // R7
    no_bark_after_bite_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bite_req |=> !bark_irq);

    // R4
    hold_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !restart) |=> $stable(count));

    // R2
    single_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !restart |=> ((count == $past(count)) || (count == CNT_W'($past(count) + 1'b1))));

    // R3
    restart_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (count == '0));

    // R2
    no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((&count) && !restart) |=> (&count));

endmodule

bind bark_bite_wdog wdog_chk #(.CNT_W(CNT_W)) u_wdog_chk (
    .clk(clk), .rst_n(rst_n), .en(en), .restart(restart), .count(count),
    .bark_irq(bark_irq), .bite_req(bite_req)
);

// File: tb/bark_bite_wdog_bench.sv
module bark_bite_wdog_bench;

    localparam int CLK_P  = 10;
    localparam int CNT_W  = 10;
    localparam int ADDR_W = 8;
    localparam int DATA_W = 32;
    localparam logic [ADDR_W-1:0] A_RST = 8'h38, A_EN = 8'h40, A_STS = 8'h44,
                                  A_WRN = 8'h4C, A_KIL = 8'h5C, A_BAD = 8'h10;
    localparam int CMAX = (1 << CNT_W) - 1;

    logic              clk = 1'b0, rst_n = 1'b0, tick_en = 1'b0, bus_wr = 1'b0;
    logic [ADDR_W-1:0] bus_addr = A_STS;
    logic [DATA_W-1:0] bus_wdata = '0;
    logic [DATA_W-1:0] bus_rdata;
    logic              bark_irq, bite_req;

    int checks = 0, fails = 0, pulses = 0;
    bit model_on = 1'b0, done = 1'b0;

    // model state
    int m_cnt, m_warn, m_kill;
    bit m_en, m_spent, m_bite, m_pulse;

    always #(CLK_P/2) clk = ~clk;

    bark_bite_wdog #(.CNT_W(CNT_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_bark_bite_wdog (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bark_irq(bark_irq), .bite_req(bite_req)
    );

    function automatic logic [DATA_W-1:0] exp_status();
        return DATA_W'((m_cnt << 3) | (int'(m_bite) << 2) | (int'(m_spent) << 1) | int'(m_en));
    endfunction

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // reference model, one update per rising edge from the pre-edge inputs
    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 0; m_warn = 0; m_kill = 0;
            m_en = 0; m_spent = 0; m_bite = 0; m_pulse = 0;
        end else begin
            bit rs, kh, wh, old_bite;
            rs = bus_wr && bus_addr == A_RST && bus_wdata[0];
            kh = m_en && m_cnt >= m_kill;
            wh = m_en && m_cnt >= m_warn;
            old_bite = m_bite;
            m_pulse = 0;
            if (!m_bite) begin
                if (kh) begin m_bite = 1; m_spent = 0; end
                else if (rs) m_spent = 0;
                else if (wh && !m_spent) begin m_spent = 1; m_pulse = 1; end
            end
            if (rs) m_cnt = 0;
            else if (m_en && !old_bite && tick_en && m_cnt != CMAX) m_cnt++;
            if (bus_wr && bus_addr == A_EN)  m_en   = (bus_wdata != 0);
            if (bus_wr && bus_addr == A_WRN) m_warn = int'(bus_wdata[CNT_W-1:0]);
            if (bus_wr && bus_addr == A_KIL) m_kill = int'(bus_wdata[CNT_W-1:0]);
        end
    end

    // per-cycle comparison a quarter period after the falling edge
    always begin
        @(negedge clk);
        #(CLK_P/4);
        if (rst_n && bark_irq) pulses++;
        if (rst_n && model_on) begin
            chk(bark_irq == m_pulse, "R5 bark_irq vs model", bark_irq, m_pulse);
            chk(bite_req == m_bite, "R6 bite_req vs model", bite_req, m_bite);
            if (!bus_wr && bus_addr == A_STS)
                chk(bus_rdata == exp_status(), "R2 status vs model", bus_rdata, exp_status());
        end
    end

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            bus_wr = 1'b0; bus_addr = A_STS;
        end
    endtask

    task automatic wr(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_addr = A_STS;
    endtask

    task automatic rd(input logic [ADDR_W-1:0] a, output logic [DATA_W-1:0] d);
        @(negedge clk);
        bus_wr = 1'b0; bus_addr = a;
        #(CLK_P/4);
        d = bus_rdata;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; bus_wr = 1'b0; bus_addr = A_STS; tick_en = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        pulses = 0;
    endtask

    initial begin
        #(CLK_P * 190000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [DATA_W-1:0] d, d2;
        void'($urandom(32'd2024));

        // R1 reset state
        do_reset();
        #(CLK_P/4);
        chk(bus_rdata == 0, "R1 status after reset", bus_rdata, 0);
        chk(bark_irq == 0 && bite_req == 0, "R1 outputs after reset", {bark_irq, bite_req}, 0);
        rd(A_WRN, d);
        chk(d == 0, "R1 warn threshold after reset", d, 0);
        model_on = 1'b1;

        // R8 readback, truncation, unmapped offset
        wr(A_WRN, 32'h2AB);
        rd(A_WRN, d);
        chk(d == 32'h2AB, "R8 warn readback", d, 32'h2AB);
        wr(A_KIL, 32'hFFFFF);
        rd(A_KIL, d);
        chk(d == 32'h3FF, "R8 kill readback truncated", d, 32'h3FF);
        wr(A_BAD, 32'hFFFF_FFFF);
        rd(A_BAD, d);
        chk(d == 0, "R8 unmapped reads zero", d, 0);
        rd(A_WRN, d);
        chk(d == 32'h2AB, "R8 unmapped write ignored", d, 32'h2AB);
        wr(A_RST, 32'h2);
        rd(A_STS, d);
        chk(d == 0, "R3 restart with bit0 clear ignored", d, 0);

        // R5 R6 normal order: warning at 5, kill at 40
        do_reset();
        wr(A_WRN, 5); wr(A_KIL, 40);
        tick_en = 1'b1;
        wr(A_EN, 1);
        idle(60);
        chk(pulses == 1, "R5 one warning pulse", pulses, 1);
        chk(bite_req == 1, "R6 kill raised", bite_req, 1);
        rd(A_STS, d);
        chk(d == 32'h14D, "R6 count frozen at kill", d, 32'h14D);
        wr(A_RST, 1);
        wr(A_EN, 0);
        rd(A_STS, d);
        chk(d == 32'h4, "R6 sticky after restart and disable", d, 32'h4);
        chk(bite_req == 1, "R6 bite_req held", bite_req, 1);

        // R7 kill before warning
        do_reset();
        wr(A_WRN, 50); wr(A_KIL, 10);
        tick_en = 1'b1;
        wr(A_EN, 1);
        idle(80);
        chk(pulses == 0, "R7 no warning after kill", pulses, 0);
        chk(bite_req == 1, "R7 kill raised", bite_req, 1);

        // R4 disable stops everything
        do_reset();
        wr(A_WRN, 20); wr(A_KIL, 20);
        tick_en = 1'b1;
        wr(A_EN, 1);
        idle(5);
        wr(A_EN, 0);
        rd(A_STS, d);
        idle(50);
        rd(A_STS, d2);
        chk(d2 == d, "R4 count holds while off", d2, d);
        chk(bite_req == 0 && pulses == 0, "R4 no outputs while off", {bark_irq, bite_req}, 0);
        rd(A_EN, d);
        chk(d == 0, "R4 enable reads zero", d, 0);

        // R3 R5 restart re-arms the warning
        do_reset();
        wr(A_WRN, 3); wr(A_KIL, 1000);
        tick_en = 1'b1;
        wr(A_EN, 7);
        idle(20);
        chk(pulses == 1, "R5 first warning", pulses, 1);
        rd(A_STS, d);
        chk(d[1] == 1'b1, "R5 spent flag set", d[1], 1);
        idle(20);
        chk(pulses == 1, "R5 no second warning without restart", pulses, 1);
        wr(A_RST, 1);
        rd(A_STS, d);
        chk(d[2:0] == 3'b001, "R3 flags after restart", d[2:0], 1);
        idle(20);
        chk(pulses == 2, "R3 warning re-armed", pulses, 2);

        // R2 saturation at maximum count
        do_reset();
        wr(A_WRN, CMAX); wr(A_KIL, CMAX);
        tick_en = 1'b1;
        wr(A_EN, 1);
        idle(CMAX + 80);
        rd(A_STS, d);
        chk(d == DATA_W'((CMAX << 3) | 5), "R2 count held at max", d, (CMAX << 3) | 5);

        // constrained random phase against the model
        do_reset();
        for (int c = 0; c < 20000; c++) begin
            int r;
            r = int'($urandom % 100);
            if (c % 700 == 699) do_reset();
            else begin
                @(negedge clk);
                tick_en = ($urandom % 2) == 0;
                bus_wr = 1'b0; bus_addr = A_STS;
                if (r < 3)       begin bus_wr = 1'b1; bus_addr = A_RST; bus_wdata = $urandom % 2; end
                else if (r < 5)  begin bus_wr = 1'b1; bus_addr = A_EN;  bus_wdata = ($urandom % 4) != 0; end
                else if (r < 7)  begin bus_wr = 1'b1; bus_addr = A_WRN; bus_wdata = $urandom % 64; end
                else if (r < 9)  begin bus_wr = 1'b1; bus_addr = A_KIL; bus_wdata = $urandom % 96; end
                else if (r < 10) begin bus_wr = 1'b1; bus_addr = A_BAD; bus_wdata = $urandom; end
            end
        end
        idle(2);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule